// File: doc/BRIEF.md
# Prescaled Down-Counting Timer with Output and Interrupt Routing

This block is a general-purpose counter/timer. A 16-bit down-counter advances once per prescaled tick; the ticks come from an 8-bit prescaler fed either by every cycle of the system clock or by rising edges of an external clock input. The external input is first retimed by a two-flop synchronizer and then edge-detected. When the counter sits at zero and a tick arrives, it reloads from a reload register and raises a one-cycle terminal pulse.

There are three operating modes. In timer mode a pin toggles on every terminal pulse. In PWM mode the pin is high while the count is above a compare value. In watchdog mode a terminal pulse sets a sticky expiry flag that only a write can clear, and software keeps it from firing by writing a kick.

The resulting level can be sent to one of two timer output pins. The terminal pulse can be sent to one of three interrupt request lines. Software sets everything up through a simple single-cycle register write port.

Top module: `ptmr_top`

## Requirements
- R1: While reset is held and after it is released, with no writes: count is 0, both timer pins are 0, no interrupt line is high, and the expiry flag is 0.
- R2: The prescale value P is written at address 1, using its low 8 bits. With the block enabled and the internal source selected, the counter moves once every P+1 clock cycles. Writing P restarts the prescale phase.
- R3: The counter holds its value while the enable bit (control bit 0) is 0. When enabled, it decrements by one on each prescaled tick.
- R4: When a tick arrives while the count is 0, the counter loads the reload value (address 2) and the terminal pulse is high for the following cycle, so one period is R+1 ticks. A write to address 2 loads the counter at once and restarts the prescale phase.
- R5: When control bit 1 is 1, the source is the external clock. Each rising edge counts as one prescaler event; the counter moves at the third clock edge after the input rises. Steady levels and falling edges count nothing.
- R6: Control bits 3:2 select the mode. Codes 0 and 3 are timer mode, where the level toggles on each terminal pulse. Code 1 is PWM, where the level is 1 while count > compare value (address 3). Code 2 is watchdog, where the level equals the expiry flag.
- R7: Control bit 5 selects which timer pin carries the level (0 selects pin 0, 1 selects pin 1); the other pin stays 0. Control bits 7:6 select interrupt line 0, 1 or 2, and code 3 selects none. Control bit 4 enables interrupts. A selected line repeats the terminal pulse, and at most one line is high.
- R8: In watchdog mode a terminal pulse sets the sticky expiry flag. A write to address 4 (any data) reloads the counter from the reload register and restarts the prescale phase. A write of bit 0 = 1 to address 5 clears the flag; if the flag is set in the same cycle, the set wins.
- R9: A write takes effect at the clock edge that samples it. Writes to addresses 6 and 7 change nothing visible at the ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Write data |
| ext_clk | input | 1 | Asynchronous external count source |
| count | output | 16 | Current counter value |
| tmr_out | output | 2 | Timer output pins |
| irq | output | 3 | Interrupt request lines |
| wdt_expired | output | 1 | Sticky watchdog expiry flag |

## Verification
The counter is visible on `count` in every cycle. A wrong count or a missed reload therefore shows on the next edge, and a wrong prescaler phase shows within P+1 cycles as a decrement that arrives early or late. A wrong toggle state, expiry flag or routing select reaches the pins in the same cycle as the register that holds it. The bench compares every output against a behavioural model at each clock.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
   typedef enum logic [1:0] {
      MODE_TIMER     = 2'd0,
      MODE_PWM       = 2'd1,
      MODE_WDOG      = 2'd2,
      MODE_TIMER_ALT = 2'd3
   } ptmr_mode_e;

   localparam logic [2:0] ADDR_CTRL   = 3'd0;
   localparam logic [2:0] ADDR_PSC    = 3'd1;
   localparam logic [2:0] ADDR_RELOAD = 3'd2;
   localparam logic [2:0] ADDR_CMP    = 3'd3;
   localparam logic [2:0] ADDR_KICK   = 3'd4;
   localparam logic [2:0] ADDR_CLEAR  = 3'd5;

   localparam int CB_EN     = 0;
   localparam int CB_EXT    = 1;
   localparam int CB_MODE   = 2;
   localparam int CB_IRQEN  = 4;
   localparam int CB_OSEL   = 5;
endpackage

// File: rtl/ptmr_tick_gen.sv
module ptmr_tick_gen #(
   parameter int PSC_W  = 8,
   parameter int SYNC_N = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             ext_sel,
   input  logic             ext_clk,
   input  logic [PSC_W-1:0] psc,
   input  logic             restart,
   output logic             tick
);
   generate
      if (SYNC_N < 2) begin : g_bad_sync
         $error("ptmr_tick_gen: SYNC_N must be at least 2");
      end
      if (PSC_W < 1) begin : g_bad_psc
         $error("ptmr_tick_gen: PSC_W must be at least 1");
      end
   endgenerate

   logic [SYNC_N:0]   sync_q;
   logic [PSC_W-1:0]  pcnt_q;
   logic              rise;
   logic              event_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_N-1:0], ext_clk};
   end

   assign rise    = sync_q[SYNC_N-1] & ~sync_q[SYNC_N];
   assign event_s = enable & (ext_sel ? rise : 1'b1);
   assign tick    = event_s & (pcnt_q >= psc);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pcnt_q <= '0;
      else if (restart)  pcnt_q <= '0;
      else if (event_s)  pcnt_q <= tick ? '0 : pcnt_q + 1'b1;
   end

   AST_PSC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      pcnt_q <= psc); // R2
   AST_TICK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> enable); // R3
endmodule

// File: rtl/ptmr_counter.sv
module ptmr_counter
   import ptmr_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] reload,
   input  ptmr_mode_e       mode,
   input  logic             clr_exp,
   output logic [CNT_W-1:0] cnt_q,
   output logic             tc_q,
   output logic             tog_q,
   output logic             exp_q
);
   logic tc_set;
   logic is_timer;

   assign is_timer = (mode == MODE_TIMER) || (mode == MODE_TIMER_ALT);
   assign tc_set   = tick & ~load & (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         tc_q  <= 1'b0;
      end else begin
         tc_q <= tc_set;
         if (load)                  cnt_q <= load_val;
         else if (tc_set)           cnt_q <= reload;
         else if (tick)             cnt_q <= cnt_q - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tog_q <= 1'b0;
         exp_q <= 1'b0;
      end else begin
         if (tc_set && is_timer) tog_q <= ~tog_q;
         if (tc_set && (mode == MODE_WDOG)) exp_q <= 1'b1;
         else if (clr_exp)                  exp_q <= 1'b0;
      end
   end

   AST_TC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      tc_q |-> (cnt_q == reload)); // R4
   AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(tick) && !$past(load)) |-> $stable(cnt_q)); // R3
   AST_EXP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(exp_q) && !$past(clr_exp)) |-> exp_q); // R8
endmodule

// File: rtl/ptmr_route.sv
module ptmr_route
   import ptmr_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int N_OUT  = 2,
   parameter int N_IRQ  = 3,
   parameter int OSEL_W = 1,
   parameter int ISEL_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  ptmr_mode_e        mode,
   input  logic [CNT_W-1:0]  cnt,
   input  logic [CNT_W-1:0]  cmp,
   input  logic              tog,
   input  logic              expired,
   input  logic              tc,
   input  logic              irq_en,
   input  logic [OSEL_W-1:0] osel,
   input  logic [ISEL_W-1:0] isel,
   output logic [N_OUT-1:0]  tmr_out,
   output logic [N_IRQ-1:0]  irq
);
   logic level;

   always_comb begin
      unique case (mode)
         MODE_PWM:  level = (cnt > cmp);
         MODE_WDOG: level = expired;
         default:   level = tog;
      endcase
   end

   generate
      for (genvar i = 0; i < N_OUT; i++) begin : g_pin
         assign tmr_out[i] = level & (osel == OSEL_W'(i));
      end
      for (genvar j = 0; j < N_IRQ; j++) begin : g_irq
         assign irq[j] = tc & irq_en & (isel == ISEL_W'(j));
      end
   endgenerate

   AST_IRQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(irq)); // R7
   AST_IRQ_NEEDS_TC: assert property (@(posedge clk) disable iff (!rst_n)
      (|irq) |-> tc); // R7
   AST_PIN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(tmr_out)); // R7
endmodule

// File: rtl/ptmr_top.sv
module ptmr_top
   import ptmr_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int PSC_W  = 8,
   parameter int N_OUT  = 2,
   parameter int N_IRQ  = 3,
   parameter int SYNC_N = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [2:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             ext_clk,
   output logic [CNT_W-1:0] count,
   output logic [N_OUT-1:0] tmr_out,
   output logic [N_IRQ-1:0] irq,
   output logic             wdt_expired
);
   localparam int OSEL_W  = (N_OUT > 1) ? $clog2(N_OUT) : 1;
   localparam int ISEL_W  = $clog2(N_IRQ + 1);
   localparam int CB_ISEL = CB_OSEL + OSEL_W;
   localparam int CTRL_W  = CB_ISEL + ISEL_W;

   generate
      if (CTRL_W > CNT_W) begin : g_bad_ctrl
         $error("ptmr_top: control fields do not fit the data width");
      end
      if (PSC_W > CNT_W) begin : g_bad_pscw
         $error("ptmr_top: PSC_W must not exceed CNT_W");
      end
      if (N_OUT < 1 || N_IRQ < 1) begin : g_bad_route
         $error("ptmr_top: at least one pin and one interrupt line needed");
      end
   endgenerate

   logic [CTRL_W-1:0] ctrl_q;
   logic [PSC_W-1:0]  psc_q;
   logic [CNT_W-1:0]  reload_q;
   logic [CNT_W-1:0]  cmp_q;

   logic wr_ctrl, wr_psc, wr_reload, wr_cmp, wr_kick, wr_clear;
   assign wr_ctrl   = wr_en && (wr_addr == ADDR_CTRL);
   assign wr_psc    = wr_en && (wr_addr == ADDR_PSC);
   assign wr_reload = wr_en && (wr_addr == ADDR_RELOAD);
   assign wr_cmp    = wr_en && (wr_addr == ADDR_CMP);
   assign wr_kick   = wr_en && (wr_addr == ADDR_KICK);
   assign wr_clear  = wr_en && (wr_addr == ADDR_CLEAR) && wr_data[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         psc_q    <= '0;
         reload_q <= '0;
         cmp_q    <= '0;
      end else begin
         if (wr_ctrl)   ctrl_q   <= wr_data[CTRL_W-1:0];
         if (wr_psc)    psc_q    <= wr_data[PSC_W-1:0];
         if (wr_reload) reload_q <= wr_data;
         if (wr_cmp)    cmp_q    <= wr_data;
      end
   end

   ptmr_mode_e        mode;
   logic              load;
   logic [CNT_W-1:0]  load_val;
   logic              tick;
   logic [CNT_W-1:0]  cnt;
   logic              tc, tog, expired;

   assign mode     = ptmr_mode_e'(ctrl_q[CB_MODE +: 2]);
   assign load     = wr_reload | wr_kick;
   assign load_val = wr_reload ? wr_data : reload_q;

   ptmr_tick_gen #(.PSC_W(PSC_W), .SYNC_N(SYNC_N)) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (ctrl_q[CB_EN]),
      .ext_sel (ctrl_q[CB_EXT]),
      .ext_clk (ext_clk),
      .psc     (psc_q),
      .restart (wr_psc | load),
      .tick    (tick)
   );

   ptmr_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .load     (load),
      .load_val (load_val),
      .reload   (reload_q),
      .mode     (mode),
      .clr_exp  (wr_clear),
      .cnt_q    (cnt),
      .tc_q     (tc),
      .tog_q    (tog),
      .exp_q    (expired)
   );

   ptmr_route #(
      .CNT_W(CNT_W), .N_OUT(N_OUT), .N_IRQ(N_IRQ),
      .OSEL_W(OSEL_W), .ISEL_W(ISEL_W)
   ) u_route (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode    (mode),
      .cnt     (cnt),
      .cmp     (cmp_q),
      .tog     (tog),
      .expired (expired),
      .tc      (tc),
      .irq_en  (ctrl_q[CB_IRQEN]),
      .osel    (ctrl_q[CB_OSEL +: OSEL_W]),
      .isel    (ctrl_q[CB_ISEL +: ISEL_W]),
      .tmr_out (tmr_out),
      .irq     (irq)
   );

   assign count       = cnt;
   assign wdt_expired = expired;

   AST_KICK_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_kick) |-> (count == $past(reload_q))); // R8
endmodule

// File: tb/tb_ptmr_top.sv
module tb_ptmr_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic        ext_clk = 1'b0;
   logic [15:0] count;
   logic [1:0]  tmr_out;
   logic [2:0]  irq;
   logic        wdt_expired;

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   string tag = "R1";
   bit done = 1'b0;

   ptmr_top dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .ext_clk(ext_clk), .count(count),
      .tmr_out(tmr_out), .irq(irq), .wdt_expired(wdt_expired)
   );

   always #5 clk = ~clk;

   // behavioural reference state
   int m_cnt, m_rel, m_cmp, m_psc, m_ph;
   bit [7:0] m_ctrl;
   bit m_tc, m_tog, m_exp;
   bit [2:0] m_sync;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_rel = 0; m_cmp = 0; m_psc = 0; m_ph = 0;
         m_ctrl = 0; m_tc = 0; m_tog = 0; m_exp = 0; m_sync = 0;
      end else begin
         bit ev, tk, ld, wrap, rise;
         int n_cnt, n_ph;
         rise = m_sync[1] && !m_sync[2];
         ev = m_ctrl[0] && (m_ctrl[1] ? rise : 1'b1);
         tk = ev && (m_ph >= m_psc);
         ld = wr_en && (wr_addr == 3'd2 || wr_addr == 3'd4);
         wrap = tk && !ld && (m_cnt == 0);
         n_cnt = m_cnt;
         if (wr_en && wr_addr == 3'd2) n_cnt = wr_data;
         else if (wr_en && wr_addr == 3'd4) n_cnt = m_rel;
         else if (wrap) n_cnt = m_rel;
         else if (tk) n_cnt = m_cnt - 1;
         n_ph = m_ph;
         if (ld || (wr_en && wr_addr == 3'd1)) n_ph = 0;
         else if (ev) n_ph = tk ? 0 : m_ph + 1;
         if (wrap && (m_ctrl[3:2] == 2'd0 || m_ctrl[3:2] == 2'd3)) m_tog = !m_tog;
         if (wrap && m_ctrl[3:2] == 2'd2) m_exp = 1'b1;
         else if (wr_en && wr_addr == 3'd5 && wr_data[0]) m_exp = 1'b0;
         m_tc = wrap;
         m_cnt = n_cnt;
         m_ph = n_ph;
         if (wr_en && wr_addr == 3'd0) m_ctrl = wr_data[7:0];
         if (wr_en && wr_addr == 3'd1) m_psc = wr_data[7:0];
         if (wr_en && wr_addr == 3'd2) m_rel = wr_data;
         if (wr_en && wr_addr == 3'd3) m_cmp = wr_data;
         m_sync = {m_sync[1:0], ext_clk};
      end
   end

   task automatic check(input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", tag, what, act, exp, cycles);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit lvl;
         bit [1:0] e_out;
         bit [2:0] e_irq;
         case (m_ctrl[3:2])
            2'd1: lvl = (m_cnt > m_cmp);
            2'd2: lvl = m_exp;
            default: lvl = m_tog;
         endcase
         e_out = m_ctrl[5] ? {lvl, 1'b0} : {1'b0, lvl};
         e_irq = (m_tc && m_ctrl[4] && m_ctrl[7:6] != 2'd3) ? (3'b001 << m_ctrl[7:6]) : 3'b000;
         check("count", count, m_cnt);
         check("tmr_out", tmr_out, e_out);
         check("irq", irq, e_irq);
         check("wdt_expired", wdt_expired, m_exp);
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done) begin
         done = 1'b1;
         failures++;
         $display("FAIL R1 watchdog expired actual=%0d expected<20000", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic wreg(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   initial begin
      // R1: reset state at the ports
      repeat (3) @(negedge clk);
      check("count in reset", count, 0);
      check("tmr_out in reset", tmr_out, 0);
      check("irq in reset", irq, 0);
      check("wdt_expired in reset", wdt_expired, 0);
      rst_n = 1'b1;
      idle(4);

      tag = "R4";  // periodic reload and terminal pulse, irq line 0, pin 0
      wreg(3'd2, 16'd5);
      wreg(3'd0, 16'h0011);
      idle(30);

      tag = "R2";  // prescale 2 -> move every third cycle
      wreg(3'd1, 16'd2);
      idle(40);
      wreg(3'd1, 16'd0);
      idle(6);

      tag = "R6";  // PWM on pin 1, irq line 2
      wreg(3'd3, 16'd4);
      wreg(3'd2, 16'd9);
      wreg(3'd0, 16'h00B5);
      idle(60);

      tag = "R3";  // disabled: counter holds
      wreg(3'd0, 16'h00B4);
      idle(12);

      tag = "R5";  // external source, timer, irq line 1
      wreg(3'd2, 16'd3);
      wreg(3'd0, 16'h0053);
      for (int k = 0; k < 90; k++) begin
         @(negedge clk);
         if (k % 3 == 0) ext_clk = ~ext_clk;
      end
      idle(10);  // steady level: no counting

      tag = "R8";  // watchdog with kicks, expiry, clear
      wreg(3'd1, 16'd1);
      wreg(3'd2, 16'd20);
      wreg(3'd0, 16'h0019);
      for (int k = 0; k < 4; k++) begin
         idle(15);
         wreg(3'd4, 16'h1234);
      end
      idle(60);
      wreg(3'd5, 16'h0000);  // bit 0 clear: no effect
      idle(3);
      wreg(3'd5, 16'h0001);
      idle(50);

      tag = "R7";  // interrupts routed to none, then disabled irq enable
      wreg(3'd1, 16'd0);
      wreg(3'd2, 16'd2);
      wreg(3'd0, 16'h00D1);
      idle(12);
      wreg(3'd0, 16'h0041);
      idle(12);

      tag = "R9";  // unused addresses
      wreg(3'd6, 16'hFFFF);
      wreg(3'd7, 16'hA5A5);
      idle(12);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule